// File: doc/BRIEF.md
# Circular FIFO Burst Address Generator

This block produces memory byte addresses for a set of circular sample buffers that live in system memory: four playback-side (output) channels and two capture-side (input) channels. Each channel is described by a start address, a limit address and a running pointer. Software sets these three words per channel through a plain register read/write port.

A client asks for a transfer by naming a direction, a channel and a byte count. The block checks the channel's pointer and moves it up to the start address if it lies below it. It then emits a series of (address, length) burst descriptors. No burst runs past the channel's limit, and the pointer folds back to the start address whenever it reaches the limit. When the byte count is used up, the final pointer is stored back into the channel's pointer word and a completion pulse follows. Address translation to physical pages and the data movement itself belong to the consumer of the descriptors.

Top module: `ring_burst_agu`

## Requirements
- R1: The register port decodes byte offsets. Output channel k (0..3) uses 0x24+0x10*k for start, 0x28+0x10*k for limit and 0x2C+0x10*k for pointer. Input channel k (0..1) uses 0x64+0x10*k, 0x68+0x10*k and 0x6C+0x10*k. All 32 bits of a mapped word read back as written. Any other offset, including any offset with bits [1:0] non-zero, reads as zero and ignores writes. All words reset to zero.
- R2: Start and limit addresses are bits [23:8] of their words, with the low 8 address bits zero. The pointer is bits [23:2] of its word, with the low 2 bits zero. No other bit of the three words affects any emitted address or length.
- R3: When a transfer starts with a pointer below the start address, the transfer begins at the start address.
- R4: When the effective pointer (after R3) is at or beyond the limit, `xferErr` pulses for one cycle. No burst is emitted, no register changes and `xferDone` stays low.
- R5: A request is rejected the same way as in R4 when its channel index is 4 or more with `reqDir`=1 (output), or 2 or more with `reqDir`=0 (input).
- R6: Each burst length is the smaller of (limit − pointer) and the bytes still owed. Bursts follow each other contiguously until the count reaches zero. A zero-byte request emits no burst and still completes.
- R7: When the pointer reaches the limit after a burst, the next burst starts at the start address.
- R8: On completion, bits [23:2] of the channel's pointer word take the final pointer and the remaining bits keep their value. `xferDone` pulses for one cycle, and the new value is readable in that cycle.
- R9: `reqReady` is high only while no transfer is in progress. A burst descriptor holds its address and length until `burstReady` is sampled high.
- R10: When a software write to a channel's pointer word lands in the same cycle as that channel's completion write-back, the software value is stored whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register byte offset |
| regWe | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| reqValid | input | 1 | Transfer request valid |
| reqReady | output | 1 | Request accepted when high with `reqValid` |
| reqDir | input | 1 | 1 = output channel, 0 = input channel |
| reqChan | input | 3 | Channel index within the direction |
| reqLen | input | 16 | Transfer length in bytes |
| burstValid | output | 1 | Burst descriptor valid |
| burstReady | input | 1 | Consumer takes the descriptor |
| burstAddr | output | 24 | Burst start byte address |
| burstLen | output | 16 | Burst length in bytes |
| xferDone | output | 1 | One-cycle completion pulse after write-back |
| xferErr | output | 1 | One-cycle rejection pulse |

## Verification
The completion write-back of a channel's pointer and a software write to that same word can land on the same clock edge. The bench provokes this by issuing the register write in the cycle right after it hands over the last burst of a transfer. That cycle is the write-back cycle, since completion follows the last accepted burst directly. The judgement is a read of the pointer word at the `xferDone` pulse, which must return the full software value and not the merged pointer. Around that case, a sweep covers every channel with pointers below start, inside the ring, at the last word, at the limit and beyond it. It uses lengths from zero up to several ring sizes with a stalling consumer. Each burst sequence and each write-back is compared against arithmetic done in the bench.

// File: rtl/ring_agu_pkg.sv
package ring_agu_pkg;

  typedef struct packed {
    logic latchReq;   // capture direction, channel and length
    logic loadPtr;    // load the effective pointer into the walker
    logic advance;    // a burst was taken by the consumer
    logic writeBack;  // store the walker pointer into the channel
  } agu_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_BURST = 2'd2,
    ST_WB    = 2'd3
  } agu_state_t;

  localparam logic [1:0] WSEL_START = 2'd1;
  localparam logic [1:0] WSEL_LIMIT = 2'd2;
  localparam logic [1:0] WSEL_PTR   = 2'd3;

endpackage

// File: rtl/ring_agu_datapath.sv
module ring_agu_datapath
  import ring_agu_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 16,
  parameter int RA_W    = 8,
  parameter int N_OUT   = 4,
  parameter int N_IN    = 2,
  parameter int OUT_GRP = 32'h20,
  parameter int IN_GRP  = 32'h60,
  localparam int NCH    = N_OUT + N_IN,
  localparam int CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  agu_strobe_t       strobe,
  input  logic              reqDir,
  input  logic [CH_W-1:0]   reqChan,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [RA_W-1:0]   regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              burstLive,
  output logic              chanBad,
  output logic              ptrBad,
  output logic              remZero,
  output logic              lastBurst,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen
);

  localparam int START_LSB = 8;
  localparam int PTR_LSB   = 2;
  localparam int CMP_W     = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;

  logic [31:0]      startArr [NCH];
  logic [31:0]      limitArr [NCH];
  logic [31:0]      ptrArr   [NCH];
  logic [NCH-1:0]   chanHit;
  logic [1:0]       wordIdx;
  logic             aligned;

  logic             latDir;
  logic [CH_W-1:0]  latChan;
  logic [LEN_W-1:0] rem;
  logic [ADDR_W-1:0] ptr;

  logic [CH_W-1:0]   selIdx, safeIdx;
  logic [ADDR_W-1:0] startSel, limitSel, ptrSel, effPtr, span, nextPtr;
  logic [CMP_W-1:0]  spanX, remX, minX;

  assign wordIdx = regAddr[3:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  // per-channel register groups
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int GRP_I = (c < N_OUT) ? OUT_GRP + 16 * c : IN_GRP + 16 * (c - N_OUT);
    localparam logic [RA_W-1:0] GRP_V = RA_W'(GRP_I);
    logic [31:0] startQ, limitQ, ptrQ;
    logic        swStart, swLimit, swPtr, wbHit;

    assign chanHit[c] = aligned && (regAddr[RA_W-1:4] == GRP_V[RA_W-1:4]);
    assign swStart = regWe && chanHit[c] && (wordIdx == WSEL_START);
    assign swLimit = regWe && chanHit[c] && (wordIdx == WSEL_LIMIT);
    assign swPtr   = regWe && chanHit[c] && (wordIdx == WSEL_PTR);
    assign wbHit   = strobe.writeBack && (safeIdx == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startQ <= '0;
        limitQ <= '0;
        ptrQ   <= '0;
      end else begin
        if (swStart) startQ <= regWrData;
        if (swLimit) limitQ <= regWrData;
        if (swPtr) begin
          ptrQ <= regWrData;
        end else if (wbHit) begin
          ptrQ[ADDR_W-1:PTR_LSB] <= ptr[ADDR_W-1:PTR_LSB];
        end
      end
    end

    assign startArr[c] = startQ;
    assign limitArr[c] = limitQ;
    assign ptrArr[c]   = ptrQ;
  end

  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chanHit[c]) begin
        case (wordIdx)
          WSEL_START: regRdData = startArr[c];
          WSEL_LIMIT: regRdData = limitArr[c];
          WSEL_PTR:   regRdData = ptrArr[c];
          default:    regRdData = '0;
        endcase
      end
    end
  end

  // request capture and walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latDir  <= 1'b0;
      latChan <= '0;
      rem     <= '0;
      ptr     <= '0;
    end else begin
      if (strobe.latchReq) begin
        latDir  <= reqDir;
        latChan <= reqChan;
        rem     <= reqLen;
      end
      if (strobe.loadPtr) begin
        ptr <= effPtr;
      end else if (strobe.advance) begin
        ptr <= nextPtr;
        rem <= rem - burstLen;
      end
    end
  end

  assign chanBad = latDir ? (latChan >= CH_W'(N_OUT)) : (latChan >= CH_W'(N_IN));
  assign selIdx  = latDir ? latChan : latChan + CH_W'(N_OUT);
  assign safeIdx = chanBad ? '0 : selIdx;

  assign startSel = {startArr[safeIdx][ADDR_W-1:START_LSB], {START_LSB{1'b0}}};
  assign limitSel = {limitArr[safeIdx][ADDR_W-1:START_LSB], {START_LSB{1'b0}}};
  assign ptrSel   = {ptrArr[safeIdx][ADDR_W-1:PTR_LSB], {PTR_LSB{1'b0}}};
  assign effPtr   = (ptrSel < startSel) ? startSel : ptrSel;
  assign ptrBad   = (effPtr >= limitSel);

  assign span      = limitSel - ptr;
  assign spanX     = CMP_W'(span);
  assign remX      = CMP_W'(rem);
  assign minX      = (remX < spanX) ? remX : spanX;
  assign burstLen  = LEN_W'(minX);
  assign burstAddr = ptr;
  assign remZero   = (rem == '0);
  assign lastBurst = (burstLen == rem);
  assign nextPtr   = ((ptr + ADDR_W'(burstLen)) == limitSel) ? startSel
                                                             : ptr + ADDR_W'(burstLen);

  AST_BURST_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    burstLive |-> (burstAddr >= startSel) && ((burstAddr + ADDR_W'(burstLen)) <= limitSel)); // R6
  AST_BURST_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    burstLive |-> (burstLen != '0)); // R6
  AST_CLAMP_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPtr |=> (burstAddr >= $past(startSel))); // R3
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && burstLive && !lastBurst |=> (burstAddr < limitSel)); // R7

endmodule

// File: rtl/ring_agu_control.sv
module ring_agu_control
  import ring_agu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        burstReady,
  output logic        burstValid,
  input  logic        chanBad,
  input  logic        ptrBad,
  input  logic        remZero,
  input  logic        lastBurst,
  output agu_strobe_t strobe,
  output logic        xferDone,
  output logic        xferErr
);

  agu_state_t state, stateNext;
  logic       rejectNow;

  assign reqReady   = (state == ST_IDLE);
  assign burstValid = (state == ST_BURST) && !remZero;
  assign rejectNow  = (state == ST_CHECK) && (chanBad || ptrBad);

  always_comb begin
    strobe           = '0;
    stateNext        = state;
    strobe.latchReq  = (state == ST_IDLE) && reqValid;
    strobe.advance   = burstValid && burstReady;
    strobe.writeBack = (state == ST_WB);
    case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_CHECK;
      ST_CHECK: begin
        if (chanBad || ptrBad) begin
          stateNext = ST_IDLE;
        end else begin
          strobe.loadPtr = 1'b1;
          stateNext      = ST_BURST;
        end
      end
      ST_BURST: begin
        if (remZero) stateNext = ST_WB;
        else if (strobe.advance && lastBurst) stateNext = ST_WB;
      end
      ST_WB:    stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      xferDone <= 1'b0;
      xferErr  <= 1'b0;
    end else begin
      state    <= stateNext;
      xferDone <= (state == ST_WB);
      xferErr  <= rejectNow;
    end
  end

  AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && !burstReady |=> burstValid); // R9
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !burstValid); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R9
  AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |-> !$past(burstValid) && !xferDone); // R4

endmodule

// File: rtl/ring_burst_agu.sv
module ring_burst_agu
  import ring_agu_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int RA_W   = 8,
  parameter int N_OUT  = 4,
  parameter int N_IN   = 2,
  localparam int CH_W  = $clog2(N_OUT + N_IN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RA_W-1:0]   regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqDir,
  input  logic [CH_W-1:0]   reqChan,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              burstValid,
  input  logic              burstReady,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen,
  output logic              xferDone,
  output logic              xferErr
);

  agu_strobe_t strobe;
  logic        chanBad, ptrBad, remZero, lastBurst;

  ring_agu_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .burstReady (burstReady),
    .burstValid (burstValid),
    .chanBad    (chanBad),
    .ptrBad     (ptrBad),
    .remZero    (remZero),
    .lastBurst  (lastBurst),
    .strobe     (strobe),
    .xferDone   (xferDone),
    .xferErr    (xferErr)
  );

  ring_agu_datapath #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .RA_W   (RA_W),
    .N_OUT  (N_OUT),
    .N_IN   (N_IN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqDir    (reqDir),
    .reqChan   (reqChan),
    .reqLen    (reqLen),
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .burstLive (burstValid),
    .chanBad   (chanBad),
    .ptrBad    (ptrBad),
    .remZero   (remZero),
    .lastBurst (lastBurst),
    .burstAddr (burstAddr),
    .burstLen  (burstLen)
  );

endmodule

// File: tb/tb_ring_burst_agu.sv
module tb_ring_burst_agu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqDir = 1'b0;
  logic [2:0]  reqChan = '0;
  logic [15:0] reqLen = '0;
  logic        burstValid;
  logic        burstReady = 1'b0;
  logic [23:0] burstAddr;
  logic [15:0] burstLen;
  logic        xferDone;
  logic        xferErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] shadow [6][3];

  localparam logic [31:0] PTR_MASK = 32'h00FFFFFC;
  localparam logic [31:0] ST_MASK  = 32'h00FFFF00;

  ring_burst_agu dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] regOff(input int idx, input int w);
    return (idx < 4) ? 8'(32'h24 + 16 * idx + 4 * w) : 8'(32'h64 + 16 * (idx - 4) + 4 * w);
  endfunction

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setChan(input int idx, input logic [31:0] s, input logic [31:0] l, input logic [31:0] p);
    regWrite(regOff(idx, 0), s); shadow[idx][0] = s;
    regWrite(regOff(idx, 1), l); shadow[idx][1] = l;
    regWrite(regOff(idx, 2), p); shadow[idx][2] = p;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d;
    for (int i = 0; i < 6; i++)
      for (int w = 0; w < 3; w++) begin
        regRead(regOff(i, w), d);
        check(req, d, shadow[i][w]);
      end
  endtask

  // idx = -1 selects an out-of-range channel via dirIn/chanIn
  task automatic runXfer(input logic dirIn, input logic [2:0] chanIn, input logic [15:0] len,
                         input bit collide, input logic [31:0] colVal, input string req);
    int idx;
    bit expErr;
    logic [23:0] s, l, p;
    logic [23:0] expA [32];
    logic [15:0] expL [32];
    int nExp = 0, got = 0, cyc = 0;
    logic [31:0] rem, bl;
    bit finished = 0, sawDone = 0, sawErr = 0, pendCol = 0;
    logic [31:0] d;
    idx = dirIn ? ((chanIn < 4) ? int'(chanIn) : -1) : ((chanIn < 2) ? int'(chanIn) + 4 : -1);
    if (idx < 0) begin
      expErr = 1;
      p = 0; s = 0; l = 0;
    end else begin
      s = 24'(shadow[idx][0] & ST_MASK);
      l = 24'(shadow[idx][1] & ST_MASK);
      p = 24'(shadow[idx][2] & PTR_MASK);
      if (p < s) p = s;
      expErr = (p >= l);
      if (!expErr) begin
        rem = 32'(len);
        while (rem > 0) begin
          bl = ((32'(l) - 32'(p)) < rem) ? 32'(l) - 32'(p) : rem;
          expA[nExp] = p; expL[nExp] = 16'(bl); nExp++;
          p = p + 24'(bl);
          if (p == l) p = s;
          rem = rem - bl;
        end
      end
    end
    @(negedge clk);
    check({req, " reqReady idle R9"}, 32'(reqReady), 32'd1);
    reqDir = dirIn; reqChan = chanIn; reqLen = len; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!finished && cyc < 3000) begin
      regWe = 1'b0;
      if (pendCol) begin
        regAddr = regOff(idx, 2); regWrData = colVal; regWe = 1'b1; pendCol = 0;
      end
      if (xferErr) begin sawErr = 1; finished = 1; end
      if (xferDone) begin sawDone = 1; finished = 1; end
      burstReady = 1'b0;
      if (burstValid && !finished) begin
        if (reqReady) check({req, " busy R9"}, 32'(reqReady), 32'd0);
        if ((cyc % 3) != 1) begin
          burstReady = 1'b1;
          if (got < nExp) begin
            check({req, " burst addr R6 R7"}, 32'(burstAddr), 32'(expA[got]));
            check({req, " burst len R6"}, 32'(burstLen), 32'(expL[got]));
          end else begin
            check({req, " extra burst R6"}, 32'(got), 32'(nExp));
          end
          got++;
          if (collide && got == nExp) pendCol = 1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    burstReady = 1'b0;
    regWe = 1'b0;
    check({req, " err pulse R4 R5"}, 32'(sawErr), 32'(expErr));
    check({req, " done pulse R8"}, 32'(sawDone), 32'(!expErr));
    check({req, " burst count R6"}, 32'(got), 32'(nExp));
    if (expErr) begin
      checkAll({req, " unchanged R4 R5"});
    end else begin
      if (collide) shadow[idx][2] = colVal;
      else shadow[idx][2] = (shadow[idx][2] & ~PTR_MASK) | (32'(p) & PTR_MASK);
      regRead(regOff(idx, 2), d);
      check(collide ? {req, " collision R10"} : {req, " write-back R8"}, d, shadow[idx][2]);
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [23:0] base, lim;
    logic [23:0] curs [6];
    logic [15:0] lens [5];
    for (int i = 0; i < 6; i++) for (int w = 0; w < 3; w++) shadow[i][w] = '0;
    lens[0] = 16'h0; lens[1] = 16'h4; lens[2] = 16'h40; lens[3] = 16'h100; lens[4] = 16'h204;
    repeat (3) @(negedge clk);
    check("reset burstValid", 32'(burstValid), 32'd0);
    check("reset done", 32'(xferDone), 32'd0);
    check("reset err", 32'(xferErr), 32'd0);
    rstN = 1'b1;
    check("reset reqReady R9", 32'(reqReady), 32'd1);
    checkAll("reset regs R1");

    // R1: distinct patterns to every word, then unmapped offsets
    for (int i = 0; i < 6; i++)
      for (int w = 0; w < 3; w++) begin
        regWrite(regOff(i, w), 32'hDEAD0000 ^ (32'(i) << 8) ^ 32'(w) ^ 32'h00C0FF00);
        shadow[i][w] = 32'hDEAD0000 ^ (32'(i) << 8) ^ 32'(w) ^ 32'h00C0FF00;
      end
    regWrite(8'h20, 32'h11111111);
    regWrite(8'h84, 32'h22222222);
    regWrite(8'h25, 32'h33333333);
    checkAll("readback R1");
    regRead(8'h20, d); check("unmapped 0x20 R1", d, 32'h0);
    regRead(8'h84, d); check("unmapped 0x84 R1", d, 32'h0);
    regRead(8'h25, d); check("unaligned 0x25 R1", d, 32'h0);
    regRead(8'h60, d); check("unmapped 0x60 R1", d, 32'h0);

    // R2 R3 R4 R6 R7 R8 sweep; high and low junk bits in every word
    for (int i = 0; i < 6; i++)
      for (int sz = 1; sz <= 2; sz++) begin
        base = 24'h010200 + 24'(i) * 24'h1000;
        lim  = base + 24'(sz) * 24'h100;
        curs[0] = base - 24'h40; curs[1] = base; curs[2] = base + 24'h40;
        curs[3] = lim - 24'h4;   curs[4] = lim;  curs[5] = lim + 24'h100;
        for (int ci = 0; ci < 6; ci++)
          for (int li = 0; li < 5; li++) begin
            setChan(i, 32'h5A0000FF | 32'(base), 32'hC300007F | 32'(lim), 32'hA5000003 | 32'(curs[ci]));
            runXfer(i < 4, 3'(i < 4 ? i : i - 4), lens[li], 0, 0, "sweep R2 R3");
          end
      end

    // R5: out-of-range channels in each direction
    for (int c = 4; c < 8; c++) runXfer(1'b1, 3'(c), 16'h8, 0, 0, "bad out chan R5");
    for (int c = 2; c < 8; c++) runXfer(1'b0, 3'(c), 16'h8, 0, 0, "bad in chan R5");

    // R10: software write collides with write-back
    for (int i = 0; i < 6; i++) begin
      base = 24'h080000 + 24'(i) * 24'h400;
      setChan(i, 32'(base), 32'(base + 24'h200), 32'(base + 24'h1F0));
      runXfer(i < 4, 3'(i < 4 ? i : i - 4), 16'h30, 1, 32'h77000000 | 32'(base) | 32'h2, "collide R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule